// File: doc/BRIEF.md
# Octant-Reduced Arctangent Phase Estimator

This block turns a pair of signed correlation sums, an in-phase sum `corr_a` (the x axis) and a quadrature sum `corr_b` (the y axis), into the phase angle of the measured tone. It does not use an arctangent table that covers the whole circle. It first divides the smaller magnitude by the larger one to get a ratio between 0 and 1, which corresponds to an offset angle between 0 and 45 degrees. Small ratios are turned into an angle by a linear scale. The remaining ratios index a table that holds entries only for the upper part of that single octant.

An octant mapping then places the offset on the full circle. It uses the two input signs and which input has the larger magnitude. The result is a 12-bit binary angle, where 4096 counts are one full turn. A one-cycle `start` captures the inputs. A one-cycle `phase_vld` returns the angle after a fixed latency. A pair of zero inputs has no defined angle, so it is flagged with `phase_bad`.

Top module: `phase_octant_est`

## Requirements
- R1: The offset angle always lies in 0..512 counts (0 to 45 degrees). It is derived from the ratio `r = floor(min(|a|,|b|)*1024 / max(|a|,|b|))`, a 10-bit fraction.
- R2: When r < 128 (below 1/8), the offset is `floor(r*652/1024)`. This is the ratio itself, scaled to angle counts.
- R3: When r >= 128, the offset is a table entry at index k = floor(r/16). The entry value is `round(atan(k/64)*4096/(2*pi))`. The table holds only indices 8..63 (56 entries).
- R4: The octant mapping gives the phase modulo 4096 as follows. With a >= 0 and b >= 0: off if |b| <= |a|, else 1024-off. With a < 0 and b >= 0: 2048-off, else 1024+off. With a < 0 and b < 0: 2048+off, else 3072-off. With a >= 0 and b < 0: 4096-off, else 3072+off.
- R5: Equal nonzero magnitudes give an offset of exactly 512. The phase is then 512, 1536, 2560 or 3584, depending on the quadrant.
- R6: When both inputs are zero, the phase is 0 and `phase_bad` is 1 during the `phase_vld` cycle. `phase_bad` is 0 at all other times.
- R7: `phase_vld` is high for exactly one cycle, 11 clock edges after the edge that accepts `start`.
- R8: A `start` that arrives while a computation is in progress, including during its output edge, is ignored. It produces no extra `phase_vld`, and the pending result still reflects the inputs that were originally captured.
- R9: After reset, `phase_vld` is 0, `phase_bad` is 0 and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; captures `corr_a`, `corr_b` when idle |
| corr_a | input | 16 | Signed in-phase correlation sum (x axis) |
| corr_b | input | 16 | Signed quadrature correlation sum (y axis) |
| phase | output | 12 | Binary angle, 4096 = 360 degrees |
| phase_vld | output | 1 | One-cycle strobe marking `phase` |
| phase_bad | output | 1 | With `phase_vld`: both inputs were zero |

## Verification
Each fault shows up at the ports as soon as the affected result comes out, 11 edges after its `start`. A bad quotient bit or divider remainder moves `phase` within one octant. A wrong captured sign or swap flag moves it by a quarter turn or reflects it about an octant boundary. Faults in the busy or counter state appear as a missing, early, late or doubled `phase_vld`, because the bench expects the strobe on one exact cycle. Vectors that sit on the 1/8 threshold, on equal magnitudes, on the axes and at the most negative input value target the faults that normal random data would rarely reach.

// File: rtl/phase_est_pkg.sv
// Package: shared types for the octant-reduced phase estimator.
// Assumes: nothing beyond IEEE 1800-2017.
package phase_est_pkg;

    // Geometry of one input pair, captured when a computation starts.
    typedef struct packed {
        logic neg_a;   // in-phase sum is negative
        logic neg_b;   // quadrature sum is negative
        logic swap;    // |b| > |a|: the angle lies nearer the y axis
        logic equal;   // |a| == |b|
        logic zero;    // both sums are zero
    } pair_geom_t;

endpackage

// File: rtl/mag_sorter.sv
// mag_sorter: takes absolute values of two signed words and orders them.
// Assumes: combinational only. The most negative value maps to its magnitude
// 2^(IN_W-1), which still fits in IN_W unsigned bits.
module mag_sorter
    import phase_est_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic signed [IN_W-1:0] a_in,
    input  logic signed [IN_W-1:0] b_in,
    output logic        [IN_W-1:0] mag_small,
    output logic        [IN_W-1:0] mag_large,
    output pair_geom_t             geom
);

    logic [IN_W-1:0] mag_a;
    logic [IN_W-1:0] mag_b;

    // Form magnitudes, the ordering and the geometry flags.
    always_comb begin
        mag_a      = a_in[IN_W-1] ? IN_W'(-a_in) : IN_W'(a_in);
        mag_b      = b_in[IN_W-1] ? IN_W'(-b_in) : IN_W'(b_in);
        geom.neg_a = a_in[IN_W-1];
        geom.neg_b = b_in[IN_W-1];
        geom.swap  = mag_b > mag_a;
        geom.equal = mag_b == mag_a;
        geom.zero  = (mag_a == '0) && (mag_b == '0);
        mag_small  = geom.swap ? mag_a : mag_b;
        mag_large  = geom.swap ? mag_b : mag_a;
    end

endmodule

// File: rtl/ratio_divider.sv
// ratio_divider: sequential restoring divider that produces
// floor(num * 2^Q_W / den) as a Q_W-bit fraction, one bit per cycle.
// Assumes: num <= den. The fraction saturates to all ones when num == den.
// A zero divisor yields a meaningless quotient that the caller discards.
module ratio_divider #(
    parameter int N_W = 16,
    parameter int Q_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N_W-1:0] num,
    input  logic [N_W-1:0] den,
    output logic [Q_W-1:0] quo,
    output logic           run,
    output logic           done
);

    localparam int CNT_W = $clog2(Q_W + 1);

    logic [N_W-1:0]   rem;
    logic [N_W-1:0]   den_q;
    logic [CNT_W-1:0] cnt;
    logic [N_W:0]     rem_dbl;
    logic             take;

    // One restoring step: double the remainder and subtract if it fits.
    always_comb begin
        rem_dbl = {rem, 1'b0};
        take    = rem_dbl >= {1'b0, den_q};
    end

    // Iterate Q_W steps after a load and pulse done once at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            quo   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                rem   <= num;
                den_q <= den;
                cnt   <= CNT_W'(Q_W);
                quo   <= '0;
                run   <= 1'b1;
            end else if (run) begin
                rem <= take ? N_W'(rem_dbl - {1'b0, den_q}) : rem_dbl[N_W-1:0];
                quo <= {quo[Q_W-2:0], take};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R1: the partial remainder never exceeds the divisor, so every ratio is <= 1.
    a_r1_rem_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> rem <= den_q);

endmodule

// File: rtl/octant_offset.sv
// octant_offset: maps a 0..1 ratio to a 0..45 degree offset in binary-angle
// counts. Below 1/2^LIN_SHIFT it scales the ratio linearly (atan(x) ~ x).
// Above that it reads a table that covers only the upper part of the octant.
// Assumes: ratio is an unsigned Q_W-bit fraction. The table values are
// computed at elaboration by a converging arctangent series.
module octant_offset #(
    parameter int Q_W       = 10,
    parameter int ANG_W     = 12,
    parameter int LUT_BITS  = 6,
    parameter int LIN_SHIFT = 3
) (
    input  logic [Q_W-1:0]   ratio,
    output logic [ANG_W-1:0] offset
);

    localparam real TWO_PI = 6.283185307179586;
    localparam int  LUT_N  = 1 << LUT_BITS;
    localparam int  LUT_LO = LUT_N >> LIN_SHIFT;
    localparam int  LUT_CNT = LUT_N - LUT_LO;
    localparam int  LIN_K  = int'((2.0 ** ANG_W) / TWO_PI);
    localparam int  P_W    = Q_W + ANG_W;

    // Arctangent of k/n in angle counts, from a series with ratio <= 1/2 per term.
    function automatic int atan_counts(input int k, input int n, input int aw);
        real x, y, term, sum;
        x    = real'(k) / real'(n);
        y    = (x * x) / (1.0 + x * x);
        term = x / (1.0 + x * x);
        sum  = 0.0;
        for (int j = 1; j <= 60; j++) begin
            sum  = sum + term;
            term = term * y * (2.0 * j) / (2.0 * j + 1.0);
        end
        return int'(sum * (2.0 ** aw) / TWO_PI);
    endfunction

    logic [ANG_W-1:0]    rom [LUT_CNT];
    logic [LUT_BITS-1:0] idx;
    logic [P_W-1:0]      lin_prod;
    logic                in_lin;

    for (genvar k = LUT_LO; k < LUT_N; k++) begin : g_rom
        localparam int ENTRY = atan_counts(k, LUT_N, ANG_W);
        assign rom[k - LUT_LO] = ANG_W'(ENTRY);
    end

    // Choose between the linear region and the truncated table lookup.
    always_comb begin
        idx      = ratio[Q_W-1 -: LUT_BITS];
        in_lin   = ratio < Q_W'(1 << (Q_W - LIN_SHIFT));
        lin_prod = P_W'(ratio) * P_W'(LIN_K);
        if (in_lin) offset = lin_prod[Q_W +: ANG_W];
        else        offset = rom[idx - LUT_BITS'(LUT_LO)];
    end

endmodule

// File: rtl/octant_mapper.sv
// octant_mapper: places an in-octant offset on the full circle using the
// input signs and which input has the larger magnitude. The result wraps
// modulo 2^ANG_W.
// Assumes: offset <= 1/8 turn. Combinational only.
module octant_mapper
    import phase_est_pkg::*;
#(
    parameter int ANG_W = 12
) (
    input  pair_geom_t       geom,
    input  logic [ANG_W-1:0] offset,
    output logic [ANG_W-1:0] angle
);

    localparam logic [ANG_W-1:0] QTR  = ANG_W'(1 << (ANG_W - 2));
    localparam logic [ANG_W-1:0] HALF = ANG_W'(1 << (ANG_W - 1));
    localparam logic [ANG_W-1:0] TQTR = QTR + HALF;

    // Octant table indexed by {neg_a, neg_b, swap}.
    always_comb begin
        unique case ({geom.neg_a, geom.neg_b, geom.swap})
            3'b000:  angle = offset;
            3'b001:  angle = QTR - offset;
            3'b100:  angle = HALF - offset;
            3'b101:  angle = QTR + offset;
            3'b110:  angle = HALF + offset;
            3'b111:  angle = TQTR - offset;
            3'b010:  angle = '0 - offset;
            default: angle = TQTR + offset;
        endcase
    end

endmodule

// File: rtl/phase_octant_est.sv
// phase_octant_est: phase of a measured tone from two signed correlation
// sums. It captures the inputs on an idle start, divides the smaller
// magnitude by the larger, converts the ratio to an in-octant offset and
// maps it onto the circle. The strobe comes Q_W+1 edges after start.
// Assumes: start is ignored while busy. Inputs only need to be stable
// in the start cycle.
module phase_octant_est
    import phase_est_pkg::*;
#(
    parameter int IN_W      = 16,
    parameter int Q_W       = 10,
    parameter int ANG_W     = 12,
    parameter int LUT_BITS  = 6,
    parameter int LIN_SHIFT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic signed [IN_W-1:0] corr_a,
    input  logic signed [IN_W-1:0] corr_b,
    output logic [ANG_W-1:0]       phase,
    output logic                   phase_vld,
    output logic                   phase_bad
);

    localparam logic [ANG_W-1:0] EIGHTH = ANG_W'(1 << (ANG_W - 3));

    logic [IN_W-1:0]  mag_small;
    logic [IN_W-1:0]  mag_large;
    pair_geom_t       geom_in;
    pair_geom_t       geom_q;
    logic [Q_W-1:0]   ratio;
    logic             div_run;
    logic             div_done;
    logic             busy;
    logic             accept;
    logic [ANG_W-1:0] lut_off;
    logic [ANG_W-1:0] off_sel;
    logic [ANG_W-1:0] mapped;

    mag_sorter #(.IN_W(IN_W)) u_sort (
        .a_in(corr_a), .b_in(corr_b),
        .mag_small(mag_small), .mag_large(mag_large), .geom(geom_in)
    );

    ratio_divider #(.N_W(IN_W), .Q_W(Q_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .num(mag_small), .den(mag_large),
        .quo(ratio), .run(div_run), .done(div_done)
    );

    octant_offset #(.Q_W(Q_W), .ANG_W(ANG_W), .LUT_BITS(LUT_BITS),
                    .LIN_SHIFT(LIN_SHIFT)) u_off (
        .ratio(ratio), .offset(lut_off)
    );

    octant_mapper #(.ANG_W(ANG_W)) u_map (
        .geom(geom_q), .offset(off_sel), .angle(mapped)
    );

    // Accept a new request only when no computation is running or finishing.
    always_comb begin
        busy    = div_run | div_done;
        accept  = start & ~busy;
        off_sel = geom_q.equal ? EIGHTH : lut_off;
    end

    // Hold the geometry of the accepted pair until its result leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)      geom_q <= '0;
        else if (accept) geom_q <= geom_in;
    end

    // Register the final angle and strobes on the divider's done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            phase_vld <= 1'b0;
            phase_bad <= 1'b0;
        end else begin
            phase_vld <= div_done;
            phase_bad <= div_done & geom_q.zero;
            if (div_done) phase <= geom_q.zero ? '0 : mapped;
        end
    end

    // R1: the offset used for mapping never exceeds one eighth of a turn.
    a_r1_offset_in_octant: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> off_sel <= EIGHTH);

    // R7: the result strobe lasts a single cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |=> !phase_vld);

    // R6: the zero-input flag only appears with a strobe and a zero angle.
    a_r6_bad_with_zero: assert property (@(posedge clk) disable iff (!rst_n)
        phase_bad |-> (phase_vld && phase == '0));

    // R8: a start while busy leaves the captured geometry untouched.
    a_r8_busy_keeps_geom: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(geom_q));

endmodule

// File: tb/tb_phase_octant_est.sv
`timescale 1ns/1ps
// Bench: behavioural reference with a queue of pending results, each due on
// a specific cycle. The strobe, angle and flag are compared on every clock.
module tb_phase_octant_est;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic signed [15:0] corr_a = '0;
    logic signed [15:0] corr_b = '0;
    logic [11:0]        phase;
    logic               phase_vld;
    logic               phase_bad;

    phase_octant_est dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .corr_a(corr_a), .corr_b(corr_b),
        .phase(phase), .phase_vld(phase_vld), .phase_bad(phase_bad)
    );

    always #5 clk = ~clk;

    typedef struct {
        int due;
        int ph;
        bit bad;
        int tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   last_due = -1;
    bit   checking = 1'b0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic string tag_name(input int t);
        case (t)
            2: return "R2,R4";
            3: return "R3,R4";
            5: return "R5";
            6: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Reference phase from the requirement text (R1..R6).
    function automatic void ref_phase(input int a, input int b,
                                      output int ph, output bit zf, output int tag);
        int ma, mb, mn, mx, r, off;
        ma = (a < 0) ? -a : a;
        mb = (b < 0) ? -b : b;
        zf = 1'b0;
        if (ma == 0 && mb == 0) begin
            ph = 0; zf = 1'b1; tag = 6;
            return;
        end
        mn = (mb > ma) ? ma : mb;
        mx = (mb > ma) ? mb : ma;
        r  = (mn * 1024) / mx;
        if (ma == mb) begin
            off = 512; tag = 5;
        end else if (r < 128) begin
            off = (r * 652) / 1024; tag = 2;
        end else begin
            off = $rtoi($atan(real'(r / 16) / 64.0) * 4096.0 / 6.283185307179586 + 0.5);
            tag = 3;
        end
        if (a >= 0 && b >= 0)     ph = (mb > ma) ? 1024 - off : off;
        else if (a < 0 && b >= 0) ph = (mb > ma) ? 1024 + off : 2048 - off;
        else if (a < 0)           ph = (mb > ma) ? 3072 - off : 2048 + off;
        else                      ph = (mb > ma) ? 3072 + off : 4096 - off;
        ph = ph % 4096;
    endfunction

    // Drive one start pulse; the model accepts it only if idle (R8).
    task automatic issue(input int a, input int b);
        exp_t e;
        @(negedge clk);
        corr_a = 16'(a);
        corr_b = 16'(b);
        start  = 1'b1;
        if (cyc >= last_due) begin
            e.due = cyc + 12;
            ref_phase(a, b, e.ph, e.bad, e.tag);
            exp_q.push_back(e);
            last_due = e.due;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Compare every clock: strobe timing (R7), angle and flag.
    always @(negedge clk) begin
        if (checking) begin
            bit want;
            want = (exp_q.size() > 0) && (exp_q[0].due == cyc);
            total++;
            if (phase_vld !== want) begin
                bad++;
                $display("FAIL R7: phase_vld=%0b expected %0b at cycle %0d", phase_vld, want, cyc);
            end else if (!want && phase_bad !== 1'b0) begin
                bad++;
                $display("FAIL R6: phase_bad=%0b expected 0 without strobe", phase_bad);
            end
            if (want) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (phase !== 12'(e.ph) || phase_bad !== e.bad) begin
                    bad++;
                    $display("FAIL %s: phase=%0d bad=%0b expected phase=%0d bad=%0b",
                             tag_name(e.tag), phase, phase_bad, e.ph, e.bad);
                end
            end
        end
    end

    initial begin
        int seed;
        #200_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s;
        idle(3);
        // R9: reset state of the outputs.
        total++;
        if (phase_vld !== 1'b0 || phase_bad !== 1'b0 || phase !== 12'd0) begin
            bad++;
            $display("FAIL R9: vld=%0b bad=%0b phase=%0d expected 0 0 0",
                     phase_vld, phase_bad, phase);
        end
        rst_n = 1'b1;
        checking = 1'b1;
        idle(2);
        issue(1000, 50);     idle(14);  // R2 linear region
        issue(1000, 600);    idle(14);  // R3 table region
        issue(1000, 125);    idle(14);  // R3 exactly at 1/8
        issue(1000, 124);    idle(14);  // R2 just below 1/8
        issue(-300, 900);    idle(14);  // R4 second quadrant, swapped
        issue(-700, -200);   idle(14);  // R4 third quadrant
        issue(200, -700);    idle(14);  // R4 fourth quadrant, swapped
        issue(100, -1);      idle(14);  // R4 wrap below 4096
        issue(500, -500);    idle(14);  // R5
        issue(-400, 400);    idle(14);  // R5
        issue(-9, -9);       idle(14);  // R5
        issue(77, 77);       idle(14);  // R5
        issue(0, 0);         idle(14);  // R6
        issue(0, 1234);      idle(14);  // R4 positive y axis
        issue(-5000, 0);     idle(14);  // R4 negative x axis
        issue(-32768, 32767); idle(14); // R3 extreme magnitudes
        issue(300, 700);     idle(2);   // R8 second start while busy
        issue(-800, 10);     idle(6);   // R8 ignored
        issue(5, 5);         idle(14);  // accepted again
        s = 12345;
        for (int n = 0; n < 60; n++) begin
            int a, b;
            s = s * 1103515245 + 12345;
            a = (s >>> 8) % 20000;
            s = s * 1103515245 + 12345;
            b = ((s >>> 8) % 20000) >>> (n % 5);
            issue(a, b);
            idle((s >>> 4) & 15);
        end
        idle(20);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R7: %0d results never arrived, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule